// File: doc/BRIEF.md
# Data Address Generation Unit

This block turns load and store requests of an 8-bit microcontroller core into data-space addresses and carries out the access. A request selects one of five addressing modes: absolute, pointer, pointer plus a small unsigned offset, pointer with decrement before use, and pointer with increment after use. The three 16-bit pointers live in the upper six bytes of a 32-byte general-purpose register file that the block holds. The block writes back each pointer that a mode changes. The resulting address is sorted into one of three windows: general registers at the bottom, then 64 I/O bytes, then 1024 bytes of SRAM. Any address above these windows is flagged as out of range.

Requests use a valid/ready handshake. A request is taken only in `ST_IDLE`. A register or I/O access, or an out-of-range access, goes straight to `ST_RESPOND`. An SRAM access passes through `ST_SRAM_BUSY`, where the behavioural memory is clocked, and then goes to `ST_RESPOND`. `ST_RESPOND` raises `done` for one cycle and always returns to `ST_IDLE`. The region flags and the offset stay valid from the cycle after acceptance until the end of `ST_RESPOND`.

Top module: `dau_top`

## Requirements
- R1: Mode code 0 (direct) uses `req_addr` as the effective address, so any 16-bit address can be reached. Codes 5 to 7 behave as direct.
- R2: Mode code 1 (indirect) uses the selected pointer unchanged and does not write it back. Pointer code 0 selects X (R27 high, R26 low), code 1 selects Y (R29:R28), and codes 2 and 3 select Z (R31:R30).
- R3: Mode code 2 adds the unsigned 6-bit `req_disp` (0..63) to Y or Z, with a modulo 2^16 sum. With X the displacement is ignored and X itself is the address.
- R4: Mode code 3 (pre-decrement) uses pointer−1 as the address and writes pointer−1 back. 0x0000 wraps to 0xFFFF.
- R5: Mode code 4 (post-increment) uses the pointer as the address and writes pointer+1 back, with 0xFFFF wrapping to 0x0000. The next accepted request sees the new value.
- R6: Addresses 0x0000–0x001F select the register file (`sel_rf`), with the address as the offset. At most one region select is high at a time.
- R7: Addresses 0x0020–0x005F select the I/O bytes (`sel_io`), with offset = address − 0x20. The I/O bytes reset to 0x00.
- R8: Addresses 0x0060–0x045F select the SRAM (`sel_sram`), with offset = address − 0x60.
- R9: An address of 0x0460 or above raises `out_of_range`, selects no region and reports offset 0. A write there changes no storage, and a read returns 0x00.
- R10: A register, I/O or out-of-range access raises `done` one cycle after acceptance. An SRAM access raises it two cycles after acceptance. `req_ready` is high only in `ST_IDLE`.
- R11: A store to a pointer byte through the data space changes that pointer. When the same request also writes back that byte, the stored data wins.
- R12: After reset `req_ready` is 1, `done` and all selects are 0, and every general register reads 0x00. `rdata` is 0x00 for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 2 | Pointer select code |
| req_addr | input | 16 | Direct address |
| req_disp | input | 6 | Unsigned displacement |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8 | Store data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Load data, valid with `done` |
| sel_rf | output | 1 | Access hit the register file |
| sel_io | output | 1 | Access hit the I/O bytes |
| sel_sram | output | 1 | Access hit the SRAM |
| out_of_range | output | 1 | Address beyond decoded space |
| region_off | output | 10 | Offset inside the selected region |

## Verification
A corrupt pointer byte shows up at the ports on the very next pointer-based access: the offset or region moves, and reading the pointer bytes back through direct access gives the wrong value. A stale or missed write-back shows up the same way one request later. A state machine that skips `ST_SRAM_BUSY`, or stays in it too long, changes the measured latency to `done` at once. An incorrect region boundary moves the select or the offset on the first access near 0x20, 0x60 or 0x460.

// File: rtl/dau_pkg.sv
package dau_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SRAM_BUSY = 2'd1,
        ST_RESPOND   = 2'd2
    } state_e;

    typedef struct packed {
        logic oor;
        logic sram;
        logic io;
        logic rf;
    } region_t;
endpackage

// File: rtl/dau_regfile.sv
module dau_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_GPR  = 32,
    parameter int PTR_BASE = 26,
    localparam int ADDR_W  = 2 * DATA_W,
    localparam int IW      = $clog2(NUM_GPR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IW-1:0]           rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    ptr_we,
    input  logic [1:0]              ptr_idx,
    input  logic [ADDR_W-1:0]       ptr_new,
    output logic [2:0][ADDR_W-1:0]  ptr_vals
);
    logic [DATA_W-1:0] gpr [NUM_GPR];
    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;

    assign lo_idx  = IW'(PTR_BASE + 2 * int'(ptr_idx));
    assign hi_idx  = IW'(PTR_BASE + 2 * int'(ptr_idx) + 1);
    assign rd_data = gpr[rd_idx];

    for (genvar g = 0; g < 3; g++) begin : g_ptr
        assign ptr_vals[g] = {gpr[PTR_BASE + 2*g + 1], gpr[PTR_BASE + 2*g]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
        end else begin
            if (ptr_we) begin
                gpr[lo_idx] <= ptr_new[DATA_W-1:0];
                gpr[hi_idx] <= ptr_new[ADDR_W-1:DATA_W];
            end
            // data store placed last: it overrides a write-back to the same byte
            if (wr_en) gpr[wr_idx] <= wr_data;
        end
    end

    // pointer write-back lands on the selected pair
    assert_ptr_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && !wr_en) |=> (ptr_vals[$past(ptr_idx)] == $past(ptr_new)));
endmodule

// File: rtl/dau_ea_calc.sv
module dau_ea_calc import dau_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic [2:0]              mode,
    input  logic [1:0]              ptr_sel,
    input  logic [ADDR_W-1:0]       direct_addr,
    input  logic [DISP_W-1:0]       disp,
    input  logic [2:0][ADDR_W-1:0]  ptr_vals,
    output logic [1:0]              ptr_idx,
    output logic [ADDR_W-1:0]       ea,
    output logic [ADDR_W-1:0]       ptr_new,
    output logic                    ptr_wb
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp_ext;

    assign ptr_idx  = (ptr_sel == 2'd3) ? 2'd2 : ptr_sel;
    assign base     = ptr_vals[ptr_idx];
    assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp};

    always_comb begin
        ea      = direct_addr;
        ptr_new = base;
        ptr_wb  = 1'b0;
        unique case (amode_e'(mode))
            AM_IND:     ea = base;
            AM_DISP:    ea = (ptr_idx == 2'd0) ? base : base + disp_ext;
            AM_PREDEC: begin
                ea      = base - 1'b1;
                ptr_new = base - 1'b1;
                ptr_wb  = 1'b1;
            end
            AM_POSTINC: begin
                ea      = base;
                ptr_new = base + 1'b1;
                ptr_wb  = 1'b1;
            end
            default:    ea = direct_addr;
        endcase
    end
endmodule

// File: rtl/dau_region_decode.sv
module dau_region_decode import dau_pkg::*; #(
    parameter int ADDR_W     = 16,
    parameter int NUM_GPR    = 32,
    parameter int NUM_IO     = 64,
    parameter int SRAM_BYTES = 1024,
    parameter int OFF_W      = 10
) (
    input  logic [ADDR_W-1:0] ea,
    output region_t           region,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W-1:0] IO_LO   = ADDR_W'(NUM_GPR);
    localparam logic [ADDR_W-1:0] SRAM_LO = ADDR_W'(NUM_GPR + NUM_IO);
    localparam logic [ADDR_W-1:0] TOP     = ADDR_W'(NUM_GPR + NUM_IO + SRAM_BYTES);

    logic [ADDR_W-1:0] io_rel;
    logic [ADDR_W-1:0] sram_rel;

    assign io_rel   = ea - IO_LO;
    assign sram_rel = ea - SRAM_LO;

    always_comb begin
        region = '0;
        off    = '0;
        if (ea < IO_LO) begin
            region.rf = 1'b1;
            off       = OFF_W'(ea);
        end else if (ea < SRAM_LO) begin
            region.io = 1'b1;
            off       = OFF_W'(io_rel);
        end else if (ea < TOP) begin
            region.sram = 1'b1;
            off         = OFF_W'(sram_rel);
        end else begin
            region.oor = 1'b1;
        end
    end
endmodule

// File: rtl/dau_sram.sv
module dau_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
                rdata     <= '0;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/dau_top.sv
module dau_top import dau_pkg::*; #(
    parameter int DATA_W     = 8,
    parameter int NUM_GPR    = 32,
    parameter int NUM_IO     = 64,
    parameter int SRAM_BYTES = 1024,
    parameter int DISP_W     = 6,
    parameter int PTR_BASE   = 26,
    localparam int ADDR_W    = 2 * DATA_W,
    localparam int OFF_W     = $clog2(SRAM_BYTES > NUM_IO ? SRAM_BYTES : NUM_IO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_mode,
    input  logic [1:0]        req_ptr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_rf,
    output logic              sel_io,
    output logic              sel_sram,
    output logic              out_of_range,
    output logic [OFF_W-1:0]  region_off
);
    localparam int GPR_IW = $clog2(NUM_GPR);
    localparam int IO_IW  = $clog2(NUM_IO);
    localparam int SR_IW  = $clog2(SRAM_BYTES);

    state_e state_q, state_d;
    logic   accept;

    logic [2:0][ADDR_W-1:0] ptr_vals;
    logic [1:0]             ptr_idx;
    logic [ADDR_W-1:0]      ea, ptr_new;
    logic                   ptr_wb;
    region_t                region;
    logic [OFF_W-1:0]       off;
    logic [DATA_W-1:0]      gpr_rd;

    region_t           region_q;
    logic [OFF_W-1:0]  off_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] sram_rd;
    logic [DATA_W-1:0] io_mem [NUM_IO];

    assign accept = req_valid && (state_q == ST_IDLE);

    dau_ea_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
        .mode(req_mode), .ptr_sel(req_ptr), .direct_addr(req_addr), .disp(req_disp),
        .ptr_vals(ptr_vals), .ptr_idx(ptr_idx), .ea(ea), .ptr_new(ptr_new), .ptr_wb(ptr_wb)
    );

    dau_region_decode #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR), .NUM_IO(NUM_IO),
                        .SRAM_BYTES(SRAM_BYTES), .OFF_W(OFF_W)) u_dec (
        .ea(ea), .region(region), .off(off)
    );

    dau_regfile #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .PTR_BASE(PTR_BASE)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(off[GPR_IW-1:0]), .rd_data(gpr_rd),
        .wr_en(accept && region.rf && req_we), .wr_idx(off[GPR_IW-1:0]), .wr_data(req_wdata),
        .ptr_we(accept && ptr_wb), .ptr_idx(ptr_idx), .ptr_new(ptr_new), .ptr_vals(ptr_vals)
    );

    dau_sram #(.DATA_W(DATA_W), .DEPTH(SRAM_BYTES)) u_sram (
        .clk(clk), .en(state_q == ST_SRAM_BUSY), .we(we_q),
        .addr(off_q[SR_IW-1:0]), .wdata(wdata_q), .rdata(sram_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = region.sram ? ST_SRAM_BUSY : ST_RESPOND;
            ST_SRAM_BUSY: state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // request capture, I/O storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= '0;
            off_q    <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            for (int i = 0; i < NUM_IO; i++) io_mem[i] <= '0;
        end else if (accept) begin
            region_q <= region;
            off_q    <= off;
            we_q     <= req_we;
            wdata_q  <= req_wdata;
            if (req_we) begin
                rdata_q <= '0;
                if (region.io) io_mem[off[IO_IW-1:0]] <= req_wdata;
            end else if (region.rf) begin
                rdata_q <= gpr_rd;
            end else if (region.io) begin
                rdata_q <= io_mem[off[IO_IW-1:0]];
            end else begin
                rdata_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        done         = (state_q == ST_RESPOND);
        sel_rf       = (state_q != ST_IDLE) && region_q.rf;
        sel_io       = (state_q != ST_IDLE) && region_q.io;
        sel_sram     = (state_q != ST_IDLE) && region_q.sram;
        out_of_range = (state_q != ST_IDLE) && region_q.oor;
        region_off   = (state_q != ST_IDLE) ? off_q : '0;
        rdata        = '0;
        if (state_q == ST_RESPOND) rdata = region_q.sram ? sram_rd : rdata_q;
    end

    assert_fast_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !region.sram) |=> done);
    assert_sram_two_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && region.sram) |=> (!done ##1 done));
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    assert_region_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rf, sel_io, sel_sram, out_of_range}));
    assert_oor_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_of_range) |-> (rdata == '0 && region_off == '0));
    assert_write_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_we) |=> (!done || rdata == '0));
endmodule

// File: tb/dau_top_test.sv
`timescale 1ns/1ps
module dau_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [15:0] req_addr = '0;
    logic [5:0]  req_disp = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic        sel_rf, sel_io, sel_sram, out_of_range;
    logic [9:0]  region_off;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dau_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_ptr(req_ptr), .req_addr(req_addr), .req_disp(req_disp),
        .req_we(req_we), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
        .out_of_range(out_of_range), .region_off(region_off)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  ptr;
        logic [15:0] addr;
        logic [5:0]  disp;
        logic        we;
        logic [7:0]  wd;
        logic [7:0]  exp_rd;
        logic [3:0]  exp_reg;
        logic [9:0]  exp_off;
        logic [1:0]  exp_lat;
        logic [3:0]  req;
    } vec_t;

    // region code {oor,sram,io,rf}
    localparam logic [3:0] RF = 4'h1, IO = 4'h2, SR = 4'h4, OR = 4'h8;
    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b1, 8'h70, 8'h00, RF, 10'h01A, 2'd1, 4'd1},  // R1 X lo
        '{3'd0, 2'd0, 16'h001B, 6'd0, 1'b1, 8'h00, 8'h00, RF, 10'h01B, 2'd1, 4'd6},  // R6
        '{3'd0, 2'd0, 16'h001C, 6'd0, 1'b1, 8'h5E, 8'h00, RF, 10'h01C, 2'd1, 4'd1},
        '{3'd0, 2'd0, 16'h001D, 6'd0, 1'b1, 8'h00, 8'h00, RF, 10'h01D, 2'd1, 4'd1},
        '{3'd0, 2'd0, 16'h001E, 6'd0, 1'b1, 8'hFF, 8'h00, RF, 10'h01E, 2'd1, 4'd1},
        '{3'd0, 2'd0, 16'h001F, 6'd0, 1'b1, 8'hFF, 8'h00, RF, 10'h01F, 2'd1, 4'd6},
        '{3'd1, 2'd0, 16'h0000, 6'd0, 1'b1, 8'hA5, 8'h00, SR, 10'h010, 2'd2, 4'd2},  // R2 via X
        '{3'd0, 2'd0, 16'h0070, 6'd0, 1'b0, 8'h00, 8'hA5, SR, 10'h010, 2'd2, 4'd8},  // R8
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b0, 8'h00, 8'h70, RF, 10'h01A, 2'd1, 4'd2},  // R2 no wb
        '{3'd4, 2'd0, 16'h0000, 6'd0, 1'b0, 8'h00, 8'hA5, SR, 10'h010, 2'd2, 4'd5},  // R5
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b0, 8'h00, 8'h71, RF, 10'h01A, 2'd1, 4'd5},
        '{3'd3, 2'd0, 16'h0000, 6'd0, 1'b1, 8'h3C, 8'h00, SR, 10'h010, 2'd2, 4'd4},  // R4
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b0, 8'h00, 8'h70, RF, 10'h01A, 2'd1, 4'd4},
        '{3'd0, 2'd0, 16'h0070, 6'd0, 1'b0, 8'h00, 8'h3C, SR, 10'h010, 2'd2, 4'd8},
        '{3'd2, 2'd1, 16'h0000, 6'd2, 1'b1, 8'h11, 8'h00, SR, 10'h000, 2'd2, 4'd3},  // R3 Y+2
        '{3'd2, 2'd1, 16'h0000, 6'd1, 1'b1, 8'h22, 8'h00, IO, 10'h03F, 2'd1, 4'd7},  // R7
        '{3'd1, 2'd1, 16'h0000, 6'd0, 1'b0, 8'h00, 8'h00, IO, 10'h03E, 2'd1, 4'd7},
        '{3'd0, 2'd0, 16'h005F, 6'd0, 1'b0, 8'h00, 8'h22, IO, 10'h03F, 2'd1, 4'd7},
        '{3'd2, 2'd0, 16'h0000, 6'd5, 1'b0, 8'h00, 8'h3C, SR, 10'h010, 2'd2, 4'd3},  // R3 X ignores disp
        '{3'd2, 2'd2, 16'h0000, 6'd63,1'b0, 8'h00, 8'h00, IO, 10'h01E, 2'd1, 4'd3},  // R3 wrap
        '{3'd4, 2'd2, 16'h0000, 6'd0, 1'b1, 8'h99, 8'h00, OR, 10'h000, 2'd1, 4'd9},  // R9
        '{3'd0, 2'd0, 16'h001E, 6'd0, 1'b0, 8'h00, 8'h00, RF, 10'h01E, 2'd1, 4'd5},  // R5 wrap
        '{3'd0, 2'd0, 16'h001F, 6'd0, 1'b0, 8'h00, 8'h00, RF, 10'h01F, 2'd1, 4'd5},
        '{3'd3, 2'd3, 16'h0000, 6'd0, 1'b0, 8'h00, 8'h00, OR, 10'h000, 2'd1, 4'd4},  // R4 wrap, Z alias
        '{3'd0, 2'd0, 16'h001E, 6'd0, 1'b0, 8'h00, 8'hFF, RF, 10'h01E, 2'd1, 4'd4},
        '{3'd0, 2'd0, 16'h045F, 6'd0, 1'b1, 8'h5A, 8'h00, SR, 10'h3FF, 2'd2, 4'd8},
        '{3'd0, 2'd0, 16'h045F, 6'd0, 1'b0, 8'h00, 8'h5A, SR, 10'h3FF, 2'd2, 4'd8},
        '{3'd0, 2'd0, 16'h0460, 6'd0, 1'b1, 8'h77, 8'h00, OR, 10'h000, 2'd1, 4'd9},
        '{3'd0, 2'd0, 16'h0460, 6'd0, 1'b0, 8'h00, 8'h00, OR, 10'h000, 2'd1, 4'd9},
        '{3'd0, 2'd0, 16'h0060, 6'd0, 1'b0, 8'h00, 8'h11, SR, 10'h000, 2'd2, 4'd9},
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b1, 8'h1A, 8'h00, RF, 10'h01A, 2'd1, 4'd11}, // R11
        '{3'd4, 2'd0, 16'h0000, 6'd0, 1'b1, 8'h40, 8'h00, RF, 10'h01A, 2'd1, 4'd11},
        '{3'd0, 2'd0, 16'h001A, 6'd0, 1'b0, 8'h00, 8'h40, RF, 10'h01A, 2'd1, 4'd11},
        '{3'd0, 2'd0, 16'h001B, 6'd0, 1'b0, 8'h00, 8'h00, RF, 10'h01B, 2'd1, 4'd11},
        '{3'd0, 2'd0, 16'h0020, 6'd0, 1'b0, 8'h00, 8'h00, IO, 10'h000, 2'd1, 4'd7},
        '{3'd0, 2'd0, 16'hFFFF, 6'd0, 1'b0, 8'h00, 8'h00, OR, 10'h000, 2'd1, 4'd1},
        '{3'd7, 2'd1, 16'h0070, 6'd0, 1'b0, 8'h00, 8'h3C, SR, 10'h010, 2'd2, 4'd1}   // R1 reserved code
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic access(input logic [2:0] m, input logic [1:0] p, input logic [15:0] a,
                          input logic [5:0] d, input logic w, input logic [7:0] wd,
                          output logic [7:0] rd, output logic [3:0] rg,
                          output logic [9:0] of, output int lat, output logic rdy);
        while (!req_ready) @(negedge clk);
        req_mode = m; req_ptr = p; req_addr = a; req_disp = d;
        req_we = w; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        rg = {out_of_range, sel_sram, sel_io, sel_rf};
        of = region_off;
        rdy = req_ready;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ok, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %s expected %s", tag, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] rg;
        logic [9:0] of;
        int lat;
        logic rdy;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset outputs", req_ready && !done && !sel_rf && !sel_io && !sel_sram && !out_of_range,
              $sformatf("rdy=%0b done=%0b sel=%0b%0b%0b%0b", req_ready, done, out_of_range, sel_sram, sel_io, sel_rf),
              "rdy=1 done=0 sel=0000");
        access(3'd0, 2'd0, 16'h0005, 6'd0, 1'b0, 8'h00, rd, rg, of, lat, rdy);
        check("R12 gpr reset value", rd == 8'h00, $sformatf("%02h", rd), "00");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].mode, VECS[i].ptr, VECS[i].addr, VECS[i].disp, VECS[i].we,
                   VECS[i].wd, rd, rg, of, lat, rdy);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  rd == VECS[i].exp_rd && rg == VECS[i].exp_reg && of == VECS[i].exp_off
                  && lat == int'(VECS[i].exp_lat) && !rdy,
                  $sformatf("rd=%02h reg=%h off=%03h lat=%0d rdy=%0b", rd, rg, of, lat, rdy),
                  $sformatf("rd=%02h reg=%h off=%03h lat=%0d rdy=0", VECS[i].exp_rd,
                            VECS[i].exp_reg, VECS[i].exp_off, VECS[i].exp_lat));
        end

        // R10: request held during a response is taken only after return to idle
        req_mode = 3'd0; req_addr = 16'h0001; req_we = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        check("R10 done after one cycle", done && !req_ready,
              $sformatf("done=%0b rdy=%0b", done, req_ready), "done=1 rdy=0");
        @(negedge clk);
        check("R10 ready back in idle", req_ready && !done,
              $sformatf("done=%0b rdy=%0b", done, req_ready), "done=0 rdy=1");
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R12: reset clears pointers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(3'd0, 2'd0, 16'h001E, 6'd0, 1'b0, 8'h00, rd, rg, of, lat, rdy);
        check("R12 pointer cleared by reset", rd == 8'h00, $sformatf("%02h", rd), "00");
        access(3'd0, 2'd0, 16'h005F, 6'd0, 1'b0, 8'h00, rd, rg, of, lat, rdy);
        check("R7 io cleared by reset", rd == 8'h00, $sformatf("%02h", rd), "00");

        summary();
        $finish;
    end
endmodule